// File: doc/BRIEF.md
# Banked Multi-Width Register File

This block is the general-purpose register store of a small CPU core. It holds 40 byte-wide registers. Any register can be read or written as a single byte. Aligned pairs can be accessed as 16-bit words, and aligned groups of four as 32-bit double words. Multi-byte values are big-endian: the register with the lowest index holds the most significant byte. Read results are right-justified on a 32-bit bus, and the unused upper bits read as zero.

The eight lowest byte registers are banked. Four physical copies of them exist, and two bits of the processor status word choose which copy an access sees. An interrupt handler can therefore get a fresh set of working registers by changing one status field, without saving or restoring anything. Registers 8 to 39 have a single copy that all banks share.

The file has two independent combinational read ports and one synchronous write port. A request that is misaligned, runs past register 39, or uses the reserved size code is rejected and flagged.

Top module: `bankRegFile`

## Requirements
- R1: After reset every register in every bank reads as zero.
- R2: Byte accesses (size code 0) reach registers 0 to 39. The value sits in bits 7:0 of the read data and bits 31:8 read as zero.
- R3: Word accesses (size code 1) need an even index. Register n is returned in bits 15:8, register n+1 in bits 7:0, and bits 31:16 read as zero.
- R4: Double-word accesses (size code 2) need an index that is a multiple of four. Register n is returned in bits 31:24, and registers n+1, n+2 and n+3 follow in the lower bytes.
- R5: Registers 0 to 7 come from the bank named by status-word bits 4:3. The other six status bits have no effect.
- R6: Registers 8 to 39 are one shared copy, so the same values are seen whatever bank is selected.
- R7: A write that is misaligned, runs past register 39, or uses size code 3 raises the write error output during that cycle and leaves every register unchanged.
- R8: A read with the same faults raises that port's error output, and the port returns all-zero data.
- R9: A write takes effect at the next rising clock edge. A read of the same register in the cycle of the write returns the old value.
- R10: A change of the bank field applies to reads and writes in the same cycle, with no added latency.
- R11: The two read ports are independent, and each can read any register at any size in the same cycle as the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| pswIn | input | 8 | Processor status word; bits 4:3 select the bank |
| wrEn | input | 1 | Write request |
| wrAddr | input | 6 | Byte index of the write |
| wrSize | input | 2 | Write size code: 0 byte, 1 word, 2 double word, 3 reserved |
| wrData | input | 32 | Right-justified write data |
| wrErr | output | 1 | Current write request was rejected |
| rdAddrA | input | 6 | Byte index for read port A |
| rdSizeA | input | 2 | Size code for read port A |
| rdDataA | output | 32 | Read port A data |
| rdErrA | output | 1 | Read port A request is illegal |
| rdAddrB | input | 6 | Byte index for read port B |
| rdSizeB | input | 2 | Size code for read port B |
| rdDataB | output | 32 | Read port B data |
| rdErrB | output | 1 | Read port B request is illegal |

## Verification
The bench fills every byte of every bank with a distinct value and then reads the whole file back at all three sizes from both ports.

It targets the following faults:
- **Bank decode:** the wrong bank decode, or banking registers 8 to 39, shows up as values leaking between banks.
- **Byte order:** a reversed byte order shows up as swapped lanes in the word and double-word reads.
- **Rejected writes:** every illegal index and size pair is issued as a write with all-ones data. A rejected write that still stores bytes is exposed by the full readback that follows.
- **Read timing:** a write-through path is caught by the same-cycle read check, which expects the old value.
- **Status bits:** a bank field taken from the wrong bits is caught by reads with the other status bits set.

// File: rtl/bankRegFilePkg.sv
package bankRegFilePkg;

  localparam int ADDR_W   = 6;
  localparam int BANK_W   = 2;
  localparam int NUM_RD   = 2;
  localparam int DATA_W   = 32;
  localparam int LANES    = DATA_W / 8;
  localparam int CNT_W    = $clog2(LANES + 1);

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                           wrStrobe;
    logic [ADDR_W-1:0]              wrBase;
    logic [CNT_W-1:0]               wrBytes;
    logic [BANK_W-1:0]              bank;
    logic [NUM_RD-1:0][CNT_W-1:0]   rdBytes;
  } rfCtrl_t;

  function automatic logic [CNT_W-1:0] sizeBytes(logic [1:0] s);
    case (s)
      SZ_BYTE:  return CNT_W'(1);
      SZ_WORD:  return CNT_W'(2);
      SZ_DWORD: return CNT_W'(4);
      default:  return '0;
    endcase
  endfunction

  function automatic logic accessOk(logic [ADDR_W-1:0] a, logic [1:0] s, int numRegs);
    int nb;
    nb = int'(sizeBytes(s));
    if (nb == 0) return 1'b0;
    if ((int'(a) % nb) != 0) return 1'b0;
    return (int'(a) + nb) <= numRegs;
  endfunction

endpackage

// File: rtl/rfCtrl.sv
module rfCtrl
  import bankRegFilePkg::*;
#(
  parameter int NUM_REGS     = 40,
  parameter int PSW_BANK_LSB = 3
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [7:0]                      psw,
  input  logic                            wrEn,
  input  logic [ADDR_W-1:0]               wrAddr,
  input  logic [1:0]                      wrSize,
  input  logic [NUM_RD-1:0][ADDR_W-1:0]   rdAddr,
  input  logic [NUM_RD-1:0][1:0]          rdSize,
  output rfCtrl_t                         ctrl,
  output logic                            wrErr,
  output logic [NUM_RD-1:0]               rdErr
);

  logic wrOk;

  assign wrOk          = accessOk(wrAddr, wrSize, NUM_REGS);
  assign wrErr         = wrEn && !wrOk;
  assign ctrl.wrStrobe = wrEn && wrOk;
  assign ctrl.wrBase   = wrAddr;
  assign ctrl.wrBytes  = wrOk ? sizeBytes(wrSize) : '0;
  assign ctrl.bank     = psw[PSW_BANK_LSB +: BANK_W];

  for (genvar p = 0; p < NUM_RD; p++) begin : gRdDec
    logic rdOk;
    assign rdOk            = accessOk(rdAddr[p], rdSize[p], NUM_REGS);
    assign rdErr[p]        = !rdOk;
    assign ctrl.rdBytes[p] = rdOk ? sizeBytes(rdSize[p]) : '0;
  end

  // R2: an in-range byte write is never refused
  assert_byte_write_ok_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSize == SZ_BYTE && int'(wrAddr) < NUM_REGS) |-> !wrErr);

  // R7: an odd word index is always refused
  assert_odd_word_refused_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSize == SZ_WORD && wrAddr[0]) |-> (wrErr && !ctrl.wrStrobe));

endmodule

// File: rtl/rfData.sv
module rfData
  import bankRegFilePkg::*;
#(
  parameter int NUM_REGS   = 40,
  parameter int NUM_BANKED = 8,
  parameter int NUM_BANKS  = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  rfCtrl_t                          ctrl,
  input  logic [DATA_W-1:0]                wrData,
  input  logic [NUM_RD-1:0][ADDR_W-1:0]    rdAddr,
  output logic [NUM_RD-1:0][DATA_W-1:0]    rdData
);

  localparam int PHYS   = NUM_BANKS * NUM_BANKED + NUM_REGS - NUM_BANKED;
  localparam int PHYS_W = $clog2(PHYS);

  logic [7:0] mem [PHYS];

  function automatic logic [PHYS_W-1:0] physIdx(int idx, int bank);
    int r;
    if (idx < NUM_BANKED) r = bank * NUM_BANKED + idx;
    else                  r = idx + (NUM_BANKS - 1) * NUM_BANKED;
    if (r >= PHYS) r = 0;
    return PHYS_W'(r);
  endfunction

  logic [LANES-1:0]              wrHit;
  logic [LANES-1:0][PHYS_W-1:0]  wrPhys;
  logic [LANES-1:0][7:0]         wrLane;

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      automatic int sh = (int'(ctrl.wrBytes) - 1 - k) * 8;
      wrHit[k]  = ctrl.wrStrobe && (k < int'(ctrl.wrBytes));
      wrPhys[k] = physIdx(int'(ctrl.wrBase) + k, int'(ctrl.bank));
      wrLane[k] = (sh >= 0) ? 8'(wrData >> sh) : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PHYS; i++) mem[i] <= 8'h00;
    end else begin
      for (int k = 0; k < LANES; k++)
        if (wrHit[k]) mem[wrPhys[k]] <= wrLane[k];
    end
  end

  // big-endian gather: lowest index ends up most significant
  always_comb begin
    for (int p = 0; p < NUM_RD; p++) begin
      automatic logic [DATA_W-1:0] acc = '0;
      for (int k = 0; k < LANES; k++)
        if (k < int'(ctrl.rdBytes[p]))
          acc = {acc[DATA_W-9:0],
                 mem[physIdx(int'(rdAddr[p]) + k, int'(ctrl.bank))]};
      rdData[p] = acc;
    end
  end

  logic [DATA_W-1:0] wrMasked;
  always_comb begin
    case (ctrl.wrBytes)
      CNT_W'(1): wrMasked = wrData & 32'h0000_00FF;
      CNT_W'(2): wrMasked = wrData & 32'h0000_FFFF;
      default:   wrMasked = wrData;
    endcase
  end

  // R9: a write is seen by a matching read on the next cycle
  assert_write_visible_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.wrStrobe && ctrl.wrBase == rdAddr[0] && ctrl.wrBytes == ctrl.rdBytes[0])
    |=> (!($stable(rdAddr[0]) && $stable(ctrl.bank) && $stable(ctrl.rdBytes[0]))
         || rdData[0] == $past(wrMasked)));

  // R2: byte reads keep the upper bits clear
  assert_byte_upper_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.rdBytes[1] == CNT_W'(1)) |-> (rdData[1][DATA_W-1:8] == '0));

  // R1: the file reads zero right after reset ends
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (rdData[0] == '0 && rdData[1] == '0));

endmodule

// File: rtl/bankRegFile.sv
module bankRegFile
  import bankRegFilePkg::*;
#(
  parameter int NUM_REGS     = 40,
  parameter int NUM_BANKED   = 8,
  parameter int NUM_BANKS    = 4,
  parameter int PSW_BANK_LSB = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  pswIn,
  input  logic        wrEn,
  input  logic [5:0]  wrAddr,
  input  logic [1:0]  wrSize,
  input  logic [31:0] wrData,
  output logic        wrErr,
  input  logic [5:0]  rdAddrA,
  input  logic [1:0]  rdSizeA,
  output logic [31:0] rdDataA,
  output logic        rdErrA,
  input  logic [5:0]  rdAddrB,
  input  logic [1:0]  rdSizeB,
  output logic [31:0] rdDataB,
  output logic        rdErrB
);

  rfCtrl_t                           ctrl;
  logic [NUM_RD-1:0][ADDR_W-1:0]     rdAddr;
  logic [NUM_RD-1:0][1:0]            rdSize;
  logic [NUM_RD-1:0][DATA_W-1:0]     rdData;
  logic [NUM_RD-1:0]                 rdErr;

  assign rdAddr  = {rdAddrB, rdAddrA};
  assign rdSize  = {rdSizeB, rdSizeA};
  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];
  assign rdErrA  = rdErr[0];
  assign rdErrB  = rdErr[1];

  rfCtrl #(.NUM_REGS(NUM_REGS), .PSW_BANK_LSB(PSW_BANK_LSB)) u_ctrl (
    .clk(clk), .rstN(rstN), .psw(pswIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrSize(wrSize),
    .rdAddr(rdAddr), .rdSize(rdSize),
    .ctrl(ctrl), .wrErr(wrErr), .rdErr(rdErr)
  );

  rfData #(.NUM_REGS(NUM_REGS), .NUM_BANKED(NUM_BANKED), .NUM_BANKS(NUM_BANKS)) u_data (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  // R8: a refused read returns zero data
  assert_bad_read_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdErrA |-> rdDataA == 32'h0) and (rdErrB |-> rdDataB == 32'h0));

endmodule

// File: tb/bankRegFile_tb.sv
module bankRegFile_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  pswIn = '0;
  logic        wrEn = 1'b0;
  logic [5:0]  wrAddr = '0;
  logic [1:0]  wrSize = '0;
  logic [31:0] wrData = '0;
  logic        wrErr;
  logic [5:0]  rdAddrA = '0, rdAddrB = '0;
  logic [1:0]  rdSizeA = '0, rdSizeB = '0;
  logic [31:0] rdDataA, rdDataB;
  logic        rdErrA, rdErrB;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  // reference contents, written from the requirements
  logic [7:0] bankM [4][8];
  logic [7:0] comM  [40];

  always #5 clk = ~clk;

  bankRegFile u_dut (
    .clk(clk), .rstN(rstN), .pswIn(pswIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrSize(wrSize), .wrData(wrData), .wrErr(wrErr),
    .rdAddrA(rdAddrA), .rdSizeA(rdSizeA), .rdDataA(rdDataA), .rdErrA(rdErrA),
    .rdAddrB(rdAddrB), .rdSizeB(rdSizeB), .rdDataB(rdDataB), .rdErrB(rdErrB)
  );

  function automatic int nBytes(int s);
    return (s == 0) ? 1 : (s == 1) ? 2 : (s == 2) ? 4 : 0;
  endfunction

  function automatic bit legal(int a, int s);
    int nb = nBytes(s);
    if (nb == 0) return 0;
    if (a % nb != 0) return 0;
    return (a + nb) <= 40;
  endfunction

  function automatic logic [7:0] mGet(int idx, int b);
    return (idx < 8) ? bankM[b][idx] : comM[idx];
  endfunction

  function automatic logic [31:0] mRead(int a, int s, int b);
    logic [31:0] acc = '0;
    if (!legal(a, s)) return '0;
    for (int k = 0; k < nBytes(s); k++) acc = (acc << 8) | 32'(mGet(a + k, b));
    return acc;
  endfunction

  task automatic mWrite(int a, int s, logic [31:0] d, int b);
    int nb = nBytes(s);
    for (int k = 0; k < nb; k++) begin
      logic [7:0] v = 8'(d >> (8 * (nb - 1 - k)));
      if (a + k < 8) bankM[b][a + k] = v;
      else           comM[a + k] = v;
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setBank(int b, logic [7:0] other = 8'h00);
    pswIn = (other & 8'hE7) | 8'(b << 3);
  endtask

  // write one request; returns the error flag seen in the cycle
  task automatic doWrite(int a, int s, logic [31:0] d, output logic err);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 6'(a); wrSize = 2'(s); wrData = d;
    #1 err = wrErr;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  // full byte readback of every bank through both ports
  task automatic fullCompare(string req);
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        setBank(b);
        rdAddrA = 6'(i);      rdSizeA = 2'd0;
        rdAddrB = 6'(39 - i); rdSizeB = 2'd0;
        #1;
        chk(req, rdDataA, mRead(i, 0, b));
        chk({req, " R11"}, rdDataB, mRead(39 - i, 0, b));
      end
    end
  endtask

  task automatic sizedCompare();
    for (int b = 0; b < 4; b++) begin
      for (int a = 0; a < 40; a += 2) begin
        @(negedge clk);
        setBank(b);
        rdAddrA = 6'(a); rdSizeA = 2'd1;
        rdAddrB = 6'(a - (a % 4)); rdSizeB = 2'd2;
        #1;
        chk("R3 word", rdDataA, mRead(a, 1, b));
        chk("R4 dword", rdDataB, mRead(a - (a % 4), 2, b));
      end
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic e;
    for (int b = 0; b < 4; b++) for (int i = 0; i < 8; i++) bankM[b][i] = '0;
    for (int i = 0; i < 40; i++) comM[i] = '0;

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: everything zero in every bank
    for (int b = 0; b < 4; b++)
      for (int a = 0; a < 40; a += 4) begin
        @(negedge clk);
        setBank(b); rdAddrA = 6'(a); rdSizeA = 2'd2;
        #1 chk("R1 reset", rdDataA, 32'h0);
      end

    // R2 R5 R6: distinct byte in each index under each bank
    for (int b = 0; b < 4; b++) begin
      setBank(b);
      for (int i = 0; i < 40; i++) begin
        logic [31:0] d = 32'((b * 53 + i * 7 + 1) & 8'hFF) | 32'hABCD_0000;
        doWrite(i, 0, d, e);
        chk("R2 byte wr err", 32'(e), 32'h0);
        mWrite(i, 0, d, b);
      end
    end
    fullCompare("R5 R6 bytes");
    sizedCompare();

    // R3 R4: word writes under bank 2, dword writes under bank 1
    setBank(2);
    for (int a = 0; a < 40; a += 2) begin
      logic [31:0] d = 32'hFFFF_A000 + 32'(a * 257);
      doWrite(a, 1, d, e);
      mWrite(a, 1, d, 2);
    end
    setBank(1);
    for (int a = 0; a < 40; a += 4) begin
      logic [31:0] d = 32'h1357_9BDF ^ (32'(a) * 32'h0101_0101);
      doWrite(a, 2, d, e);
      mWrite(a, 2, d, 1);
    end
    sizedCompare();
    fullCompare("R3 R4 contents");

    // R7: every illegal write refused and harmless
    for (int a = 0; a < 64; a++)
      for (int s = 0; s < 4; s++)
        if (!legal(a, s)) begin
          setBank((a + s) % 4);
          doWrite(a, s, 32'hFFFF_FFFF, e);
          chk("R7 wrErr", 32'(e), 32'h1);
        end
    fullCompare("R7 unchanged");

    // R8: illegal reads flag and return zero
    for (int a = 0; a < 64; a++)
      for (int s = 0; s < 4; s++)
        if (!legal(a, s)) begin
          @(negedge clk);
          rdAddrA = 6'(a); rdSizeA = 2'(s);
          #1;
          chk("R8 rdErr", 32'(rdErrA), 32'h1);
          chk("R8 data", rdDataA, 32'h0);
        end

    // R9: same-cycle read sees old value, next cycle sees new
    @(negedge clk);
    setBank(0);
    rdAddrA = 6'd12; rdSizeA = 2'd0;
    wrEn = 1'b1; wrAddr = 6'd12; wrSize = 2'd0; wrData = 32'h0000_005A;
    #1 chk("R9 old value", rdDataA, mRead(12, 0, 0));
    @(posedge clk);
    #1 wrEn = 1'b0;
    mWrite(12, 0, 32'h5A, 0);
    chk("R9 new value", rdDataA, 32'h0000_005A);

    // R5: bank field only; other status bits set
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      setBank(b, 8'hFF);
      rdAddrA = 6'd4; rdSizeA = 2'd2;
      rdAddrB = 6'd20; rdSizeB = 2'd1;
      #1;
      chk("R5 other psw bits", rdDataA, mRead(4, 2, b));
      chk("R6 shared", rdDataB, mRead(20, 1, b));
    end

    // R10: bank switch applies in the same cycle to writes and reads
    @(negedge clk);
    setBank(3);
    wrEn = 1'b1; wrAddr = 6'd2; wrSize = 2'd0; wrData = 32'h0000_00C3;
    @(posedge clk);
    #1 wrEn = 1'b0;
    mWrite(2, 0, 32'hC3, 3);
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      setBank(r % 4);
      rdAddrA = 6'd2; rdSizeA = 2'd0;
      #1 chk("R10 bank switch", rdDataA, mRead(2, 0, r % 4));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule